// File: doc/BRIEF.md
# Staged Bus Read-Drive Sequencer

This block sets the output-enable timing for a memory read placed onto a shared 8-bit data bus that has a heavy external load. When a read cycle aimed at the memory is flagged, the block does not switch the memory and the bus transceiver on together. First the FPGA's own data pins drive a fixed half-ones pattern. After a programmed number of clocks the transceiver is enabled, so that pattern reaches the bus. After a second programmed delay the FPGA pins go high-impedance and the SRAM output enable rises, so the stored byte replaces the pattern. Because the bus passes through an intermediate value, no more than half of its lines can rise together.

A bus-cycle detector upstream supplies a one-clock read-select strobe and a one-clock cycle-end strobe. Writes and cycles not addressed to the memory never raise the read-select strobe, so they leave all enables off. Every output is a flop. The two delays come from nanosecond parameters and the clock period: each is ceil(ns / period), with a minimum of one clock. The block has no data stream of its own, so it has no valid/ready handshake and no back-pressure. All pins are plain control levels.

Top module: `bus_read_stager`

## Requirements
- R1: While reset is high and in the first clock after it, `pre_oe`, `xcvr_oe` and `mem_oe` are 0 and `pre_data` is 8'h00.
- R2: When `rd_sel` is sampled high in idle and `cyc_end` is low, the next clock raises `pre_oe` with `pre_data` equal to `PRE_PATTERN`. The default is 8'hAA, which has exactly four 1 bits. `xcvr_oe` and `mem_oe` stay 0 in that clock. Whenever `pre_oe` is 0, `pre_data` reads 8'h00.
- R3: `xcvr_oe` rises PRE_CYC clocks after `pre_oe` rises. PRE_CYC = max(1, ceil(PRE_NS*1000 / CLK_PS)), which is 18 for 70 ns at 4000 ps.
- R4: HAND_CYC clocks after `xcvr_oe` rises (18 by default, same formula), `pre_oe` falls and `mem_oe` rises on the same edge.
- R5: `pre_oe` and `mem_oe` are never high in the same clock.
- R6: `xcvr_oe` and `mem_oe` stay high until `cyc_end` is sampled high. On the next clock all enables are 0.
- R7: A `cyc_end` sampled during the pre-drive or transceiver stage drops every enable on the next clock. `mem_oe` is never raised for that cycle.
- R8: With `rd_sel` low and the block idle, all outputs stay inactive. `cyc_end` on its own has no effect.
- R9: `rd_sel` pulses while a sequence is in progress are ignored. They neither restart nor shift the stage timing.
- R10: If `rd_sel` and `cyc_end` are sampled high together in idle, the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_sel | input | 1 | One-clock strobe: a memory read cycle has started |
| cyc_end | input | 1 | One-clock strobe: the current bus cycle is ending |
| pre_oe | output | 1 | Enable for the FPGA's own data output driver |
| pre_data | output | 8 | Value driven by the FPGA when `pre_oe` is high |
| xcvr_oe | output | 1 | Bus transceiver output enable |
| mem_oe | output | 1 | SRAM chip/output enable |

## Verification
The main sequence runs as a full read that holds in the memory stage for a while. This separates a correct stage order from a design whose delays are off by a clock, or whose hand-off overlaps or leaves a gap. Aborts placed in the pre-drive stage and in the transceiver stage show whether an early cycle end is honoured without ever opening the SRAM. Idle cycle-end pulses, a read strobe coinciding with cycle end, repeated read strobes inside a sequence and a back-to-back read right after cycle end each check one priority or ignore rule.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_XCVR = 2'd2,
    ST_MEM  = 2'd3
  } stage_t;

  // clocks needed to cover ns at a clock period of clk_ps picoseconds, at least 1
  function automatic int cycles_for(input int ns, input int clk_ps);
    int c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction
endpackage

// File: rtl/bsr_timer.sv
module bsr_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clear) count <= '0;
    else              count <= count + 1'b1;
  end
endmodule

// File: rtl/bsr_fsm.sv
module bsr_fsm
  import bsr_pkg::*;
#(
  parameter int PRE_CYC  = 18,
  parameter int HAND_CYC = 18
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   rd_sel,
  input  logic   cyc_end,
  output stage_t stage,
  output stage_t stage_nx
);
  localparam int MAXC = (PRE_CYC > HAND_CYC) ? PRE_CYC : HAND_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] count;
  logic          clear;

  always_comb begin
    stage_nx = stage;
    unique case (stage)
      ST_IDLE: if (rd_sel && !cyc_end) stage_nx = ST_PRE;
      ST_PRE: begin
        if (cyc_end)                              stage_nx = ST_IDLE;
        else if (count == CW'(PRE_CYC - 1))       stage_nx = ST_XCVR;
      end
      ST_XCVR: begin
        if (cyc_end)                              stage_nx = ST_IDLE;
        else if (count == CW'(HAND_CYC - 1))      stage_nx = ST_MEM;
      end
      ST_MEM: if (cyc_end) stage_nx = ST_IDLE;
      default: stage_nx = ST_IDLE;
    endcase
  end

  assign clear = (stage_nx != stage) || (stage == ST_IDLE) || (stage == ST_MEM);

  bsr_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clear (clear),
    .count (count)
  );

  always_ff @(posedge clk) begin
    if (rst) stage <= ST_IDLE;
    else     stage <= stage_nx;
  end

  // R9: a read strobe inside a sequence never sends it back to the first stage
  p_no_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (stage != ST_IDLE && !cyc_end) |=> (stage != ST_IDLE));

  // R7: an early end never reaches the memory stage
  p_abort_idle_r7: assert property (@(posedge clk) disable iff (rst)
    ((stage == ST_PRE || stage == ST_XCVR) && cyc_end) |=> (stage == ST_IDLE));
endmodule

// File: rtl/bus_read_stager.sv
module bus_read_stager
  import bsr_pkg::*;
#(
  parameter int          W           = 8,
  parameter int          CLK_PS      = 4000,
  parameter int          PRE_NS      = 70,
  parameter int          HAND_NS     = 70,
  parameter logic [7:0]  PRE_PATTERN = 8'hAA
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_sel,
  input  logic         cyc_end,
  output logic         pre_oe,
  output logic [W-1:0] pre_data,
  output logic         xcvr_oe,
  output logic         mem_oe
);
  localparam int PRE_CYC  = cycles_for(PRE_NS, CLK_PS);
  localparam int HAND_CYC = cycles_for(HAND_NS, CLK_PS);

  stage_t stage, stage_nx;

  bsr_fsm #(.PRE_CYC(PRE_CYC), .HAND_CYC(HAND_CYC)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .rd_sel   (rd_sel),
    .cyc_end  (cyc_end),
    .stage    (stage),
    .stage_nx (stage_nx)
  );

  // outputs registered from the next stage so they line up with the stage flop
  always_ff @(posedge clk) begin
    if (rst) begin
      pre_oe   <= 1'b0;
      pre_data <= '0;
      xcvr_oe  <= 1'b0;
      mem_oe   <= 1'b0;
    end else begin
      pre_oe   <= (stage_nx == ST_PRE) || (stage_nx == ST_XCVR);
      pre_data <= ((stage_nx == ST_PRE) || (stage_nx == ST_XCVR)) ? W'(PRE_PATTERN) : '0;
      xcvr_oe  <= (stage_nx == ST_XCVR) || (stage_nx == ST_MEM);
      mem_oe   <= (stage_nx == ST_MEM);
    end
  end

  // R5: own driver and memory never fight
  p_no_overlap_r5: assert property (@(posedge clk) disable iff (rst)
    !(pre_oe && mem_oe));

  // R2: pattern is half ones whenever driven
  p_pattern_r2: assert property (@(posedge clk) disable iff (rst)
    pre_oe |-> ($countones(pre_data) == W / 2));

  // R2: pre-drive starts alone, after a read strobe
  p_pre_first_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(pre_oe) |-> (!xcvr_oe && !mem_oe && $past(rd_sel)));

  // R3: transceiver only opens onto a driven pattern
  p_xcvr_after_pre_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(xcvr_oe) |-> $past(pre_oe));

  // R4: memory only opens behind an enabled transceiver, with the driver released
  p_mem_hand_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe) |-> ($past(xcvr_oe) && xcvr_oe && $fell(pre_oe)));

  // R6: cycle end clears everything
  p_end_clears_r6: assert property (@(posedge clk) disable iff (rst)
    cyc_end |=> (!pre_oe && !xcvr_oe && !mem_oe));

  // R8: no read strobe, nothing wakes up
  p_bypass_r8: assert property (@(posedge clk) disable iff (rst)
    (!rd_sel && !pre_oe && !xcvr_oe && !mem_oe) |=> (!pre_oe && !xcvr_oe && !mem_oe));
endmodule

// File: tb/bus_read_stager_test.sv
module bus_read_stager_test;
  localparam int PRE  = 18;  // ceil(70000/4000)
  localparam int HAND = 18;
  localparam logic [7:0] PAT = 8'hAA;

  logic clk = 1'b0, rst = 1'b1, rd_sel = 1'b0, cyc_end = 1'b0;
  logic pre_oe, xcvr_oe, mem_oe;
  logic [7:0] pre_data;

  always #2 clk = ~clk;

  bus_read_stager uut (
    .clk(clk), .rst(rst), .rd_sel(rd_sel), .cyc_end(cyc_end),
    .pre_oe(pre_oe), .pre_data(pre_data), .xcvr_oe(xcvr_oe), .mem_oe(mem_oe)
  );

  typedef struct {
    logic       doe;
    logic [7:0] dat;
    logic       xoe;
    logic       moe;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   tests = 0, fails = 0;
  bit   done = 1'b0;

  // reference model state, written from the requirements
  int mst = 0, mcnt = 0;

  task automatic push_exp(input string tag);
    exp_t e;
    e.doe = (mst == 1 || mst == 2);
    e.dat = e.doe ? PAT : 8'h00;
    e.xoe = (mst == 2 || mst == 3);
    e.moe = (mst == 3);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(input logic rd, input logic ce, input string tag);
    #1;
    rd_sel = rd; cyc_end = ce; rst = 1'b0;
    case (mst)
      0: if (rd && !ce) begin mst = 1; mcnt = 0; end
      1: if (ce) mst = 0;
         else if (mcnt == PRE - 1) begin mst = 2; mcnt = 0; end
         else mcnt++;
      2: if (ce) mst = 0;
         else if (mcnt == HAND - 1) begin mst = 3; mcnt = 0; end
         else mcnt++;
      default: if (ce) mst = 0;
    endcase
    push_exp(tag);
    @(negedge clk);
  endtask

  task automatic step_rst(input string tag);
    #1;
    rst = 1'b1; rd_sel = 1'b1; cyc_end = 1'b0;
    mst = 0; mcnt = 0;
    push_exp(tag);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, tag);
  endtask

  // monitor: compares at each falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      tests++;
      if (pre_oe !== e.doe || pre_data !== e.dat || xcvr_oe !== e.xoe || mem_oe !== e.moe) begin
        fails++;
        $display("FAIL %s: got oe=%b data=%h xcvr=%b mem=%b expected oe=%b data=%h xcvr=%b mem=%b",
                 e.tag, pre_oe, pre_data, xcvr_oe, mem_oe, e.doe, e.dat, e.xoe, e.moe);
      end
      tests++;
      if (pre_oe === 1'b1 && mem_oe === 1'b1) begin
        fails++;
        $display("FAIL R5: got oe=1 mem=1 expected not both");
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step_rst("R1"); step_rst("R1");
    step(1'b0, 1'b0, "R1");
    // R8: idle, cycle ends alone
    step(1'b0, 1'b1, "R8"); idle(2, "R8"); step(1'b0, 1'b1, "R8");
    // R10: both strobes together in idle
    step(1'b1, 1'b1, "R10"); idle(2, "R10");
    // full read R2/R3/R4/R6, with stray strobes R9
    step(1'b1, 1'b0, "R2");
    idle(3, "R3"); step(1'b1, 1'b0, "R9"); idle(PRE - 5, "R3");
    idle(4, "R4"); step(1'b1, 1'b0, "R9"); idle(HAND - 5, "R4");
    idle(6, "R6"); step(1'b1, 1'b0, "R9"); idle(3, "R6");
    step(1'b0, 1'b1, "R6"); idle(2, "R6");
    // R7: abort in the pre-drive stage
    step(1'b1, 1'b0, "R7"); idle(5, "R7"); step(1'b0, 1'b1, "R7"); idle(PRE + HAND + 3, "R7");
    // R7: abort in the transceiver stage
    step(1'b1, 1'b0, "R7"); idle(PRE + 4, "R7"); step(1'b0, 1'b1, "R7"); idle(HAND + 3, "R7");
    // back-to-back: end with a read held high, then new read
    step(1'b1, 1'b0, "R2"); idle(PRE + HAND + 2, "R4");
    step(1'b1, 1'b1, "R10"); step(1'b1, 1'b0, "R2"); idle(PRE + HAND + 1, "R4");
    step(1'b0, 1'b1, "R6"); idle(2, "R8");
    // reset in mid-sequence
    step(1'b1, 1'b0, "R2"); idle(PRE + 2, "R3"); step_rst("R1"); step(1'b0, 1'b0, "R1");
    idle(1, "R8");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule